// File: doc/BRIEF.md
# Audio Output Double-Buffer DMA Sequencer

This block moves audio samples from memory to a multichannel serializer. A system controller hands it buffers through two slots that take turns. Loading a slot gives that slot a base byte address and a length in bytes and arms it. The block plays slot 0 first, then slot 1, then slot 0 again, and continues in that order. A prefetch FIFO of 32-bit words is filled by 16-byte burst reads on a simple request/grant memory port, and read data returns in order. On every sample-rate strobe the block takes one frame of words from the FIFO and presents it as eight 32-bit lanes to the serializer.

When a buffer has been fully played, the slot's done bit rises, an interrupt is raised and the slot is freed for the next load. If a strobe finds less than one frame of data, the block repeats the last frame instead of stopping and sets a sticky underrun flag. Only a dedicated clear removes that flag. A load aimed at a slot that is still armed is dropped and recorded in a sticky error flag. Buffer lengths must be nonzero multiples of both 16 bytes and the frame size. The default FIFO depth of 32 words holds the largest prefetch the modes need (3 frames of 8 × 32-bit samples) plus one burst.

Top module: `audio_dma_seq`

## Requirements
- R1: Frame layout. `cfg_chans` values 0, 1, 2 and 3 select 2, 4, 6 and 8 channels. `cfg_wide`=1 selects 32-bit samples and 0 selects 16-bit samples. Lane n sits at `frame_data[32n+31:32n]`, and lanes that the mode does not use are zero.
  - In 32-bit mode, FIFO word k of the frame is lane k.
  - In 16-bit mode, word k gives lane 2k from bits 15:0 and lane 2k+1 from bits 31:16, each zero-extended.
  - Words are taken from memory in ascending byte address.
- R2: After the first accepted load, each `fs_strobe` cycle produces exactly one `frame_valid` pulse in the following cycle, and `frame_valid` never pulses without a strobe.
- R3: Slots are played in the order 0, 1, 0, 1 and so on. The first frame of the next slot's buffer follows the last frame of the previous buffer on the very next strobe, with no gap or repeat.
- R4: When the last frame of a slot's buffer is output, that slot's `buf_done` bit (bit 0 for slot 0, bit 1 for slot 1) is set and `irq` goes high. An accepted load of the slot clears that bit.
- R5: A strobe that finds fewer words in the FIFO than one frame leaves `frame_data` unchanged and still pulses `frame_valid`. It also sets `underrun`.
- R6: `underrun` stays set through slot loads and is cleared only by `udr_clear`.
- R7: A load (`slot_load[s]`) to a slot that is still armed does not change that slot's address or length, and it sets `load_err`. `err_clear` clears `load_err`.
- R8: Memory reads are 16-byte bursts of four words at consecutive addresses from the slot base. A burst is requested only when the FIFO has room for four more words after counting words still in flight. While a request waits for grant, it holds its address. With no strobes, the FIFO therefore takes in exactly its depth of words, and it requests again only once four words have been drained.
- R9: Before the first accepted load after reset, strobes produce no frame and do not set `underrun`.
- R10: After reset, all outputs are zero and no memory request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_chans | input | 2 | Channel count select (2/4/6/8) |
| cfg_wide | input | 1 | 1 = 32-bit samples, 0 = 16-bit |
| slot_load | input | 2 | Per-slot load strobe (bit s loads slot s) |
| load_addr | input | ADDR_W | Buffer base byte address for a load |
| load_len | input | LEN_W | Buffer length in bytes for a load |
| udr_clear | input | 1 | Clears the underrun flag |
| err_clear | input | 1 | Clears the load error flag |
| mem_req | output | 1 | Burst read request |
| mem_addr | output | ADDR_W | Burst start byte address |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data word valid |
| mem_rdata | input | 32 | Read data word |
| fs_strobe | input | 1 | Sample-rate strobe, one cycle per frame |
| frame_valid | output | 1 | Frame presented (one cycle after strobe) |
| frame_data | output | 256 | Eight 32-bit sample lanes |
| buf_done | output | 2 | Per-slot buffer finished |
| irq | output | 1 | Any buffer done |
| underrun | output | 1 | Sticky underrun flag |
| load_err | output | 1 | Sticky load-to-armed-slot flag |

## Verification
The frame path is tried in all eight channel and width combinations. Each combination uses two back-to-back buffers, and every frame is compared against words computed from the address. These runs separate the 16-bit and 32-bit lane packing and the word count per frame. They also catch a dropped or repeated frame at the switch between slots. A long buffer with no strobes shows the fill limit and the four-word drain needed before the next burst. A deliberately short buffer shows frame replay and flag stickiness across a new load. A repeated load to an armed slot confirms that the original data still plays.

// File: rtl/audio_dma_seq.sv
module audio_dma_seq #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int DEPTH  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_chans,
  input  logic              cfg_wide,
  input  logic [1:0]        slot_load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [LEN_W-1:0]  load_len,
  input  logic              udr_clear,
  input  logic              err_clear,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  input  logic              fs_strobe,
  output logic              frame_valid,
  output logic [255:0]      frame_data,
  output logic [1:0]        buf_done,
  output logic              irq,
  output logic              underrun,
  output logic              load_err
);
  localparam int PW    = $clog2(DEPTH);
  localparam int CW    = PW + 1;
  localparam int BURST = 4;
  localparam int LANES = 8;
  localparam logic [CW:0] FILL_LIM = (CW+1)'(DEPTH - BURST);

  logic [31:0]       fifo_mem [DEPTH];
  logic [PW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     count, inflight;
  logic [CW:0]       used;
  logic [3:0]        wpf;
  logic [LEN_W-1:0]  fbytes;
  logic [ADDR_W-1:0] base_q [2];
  logic [LEN_W-1:0]  len_q [2];
  logic [1:0]        armed, pend, accept;
  logic              fslot, pslot, started;
  logic [LEN_W-1:0]  foff, poff;
  logic              grant, pop, short;
  logic [31:0]       word [LANES];
  logic [255:0]      nxt;

  assign wpf      = cfg_wide ? ({1'b0, cfg_chans, 1'b0} + 4'd2) : ({2'b00, cfg_chans} + 4'd1);
  assign fbytes   = LEN_W'({wpf, 2'b00});
  assign used     = {1'b0, count} + {1'b0, inflight};
  assign mem_req  = pend[fslot] && (used <= FILL_LIM);
  assign mem_addr = base_q[fslot] + ADDR_W'(foff);
  assign grant    = mem_req && mem_gnt;
  assign short    = count < CW'(wpf);
  assign pop      = fs_strobe && started && !short;
  assign accept   = slot_load & ~armed;
  assign irq      = |buf_done;

  for (genvar k = 0; k < LANES; k++) begin : g_tap
    assign word[k] = fifo_mem[rd_ptr + PW'(k)];
  end

  always_comb begin
    nxt = '0;
    if (cfg_wide) begin
      for (int k = 0; k < LANES; k++)
        if (k < int'(wpf)) nxt[k*32 +: 32] = word[k];
    end else begin
      for (int k = 0; k < LANES/2; k++)
        if (k < int'(wpf)) begin
          nxt[(2*k)*32 +: 32]   = {16'h0, word[k][15:0]};
          nxt[(2*k+1)*32 +: 32] = {16'h0, word[k][31:16]};
        end
    end
  end

  always_ff @(posedge clk)
    if (mem_rvalid) fifo_mem[wr_ptr] <= mem_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0; rd_ptr <= '0; count <= '0; inflight <= '0;
      armed <= '0; pend <= '0; fslot <= 1'b0; pslot <= 1'b0; started <= 1'b0;
      foff <= '0; poff <= '0;
      frame_valid <= 1'b0; frame_data <= '0; buf_done <= '0;
      underrun <= 1'b0; load_err <= 1'b0;
      for (int s = 0; s < 2; s++) begin
        base_q[s] <= '0;
        len_q[s]  <= '0;
      end
    end else begin
      wr_ptr      <= wr_ptr + PW'(mem_rvalid);
      inflight    <= inflight + (grant ? CW'(BURST) : '0) - CW'(mem_rvalid);
      count       <= count + CW'(mem_rvalid) - (pop ? CW'(wpf) : '0);
      frame_valid <= fs_strobe && started;
      underrun    <= (underrun && !udr_clear) || (fs_strobe && started && short);
      load_err    <= (load_err && !err_clear) || |(slot_load & armed);
      if (grant) begin
        if (foff + LEN_W'(16) >= len_q[fslot]) begin
          pend[fslot] <= 1'b0;
          fslot       <= ~fslot;
          foff        <= '0;
        end else begin
          foff <= foff + LEN_W'(16);
        end
      end
      if (pop) begin
        rd_ptr     <= rd_ptr + PW'(wpf);
        frame_data <= nxt;
        if (poff + fbytes >= len_q[pslot]) begin
          buf_done[pslot] <= 1'b1;
          armed[pslot]    <= 1'b0;
          pslot           <= ~pslot;
          poff            <= '0;
        end else begin
          poff <= poff + fbytes;
        end
      end
      for (int s = 0; s < 2; s++)
        if (accept[s]) begin
          base_q[s]   <= load_addr;
          len_q[s]    <= load_len;
          armed[s]    <= 1'b1;
          pend[s]     <= 1'b1;
          buf_done[s] <= 1'b0;
          started     <= 1'b1;
        end
    end
  end

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr));
  // R8
  fifo_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rvalid |-> count < CW'(DEPTH));
  // R6
  udr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun && !udr_clear |=> underrun);
  // R5
  udr_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fs_strobe && started && short |=> frame_valid && $stable(frame_data));
  // R7
  load_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |(slot_load & armed) |=> load_err);
  // R2
  frame_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> $past(fs_strobe));
endmodule

// File: tb/audio_dma_seq_bench.sv
module audio_dma_seq_bench;
  localparam int LAT = 5;
  // {chans[7:6], wide[5], frames per 96-byte buffer[4:0]}
  localparam logic [7:0] VEC [8] = '{8'h18, 8'h4C, 8'h88, 8'hC6, 8'h2C, 8'h66, 8'hA4, 8'hE3};

  logic clk = 0, rst_n = 0;
  logic [1:0] cfg_chans = 0, slot_load = 0;
  logic cfg_wide = 0, udr_clear = 0, err_clear = 0, fs_strobe = 0;
  logic [31:0] load_addr = 0;
  logic [15:0] load_len = 0;
  logic mem_req, mem_gnt, frame_valid, irq, underrun, load_err;
  logic mem_rvalid = 0;
  logic [31:0] mem_addr, mem_rdata = 0;
  logic [255:0] frame_data;
  logic [1:0] buf_done, gcnt = 0;
  logic [31:0] aq[$];
  int tq[$];
  int cyc = 0, beats = 0, tests = 0, fails = 0;
  bit finished = 0;

  audio_dma_seq u_audio_dma_seq (.*);

  always #10 clk = ~clk;
  assign mem_gnt = gcnt != 2'd3;

  function automatic logic [31:0] mword(input logic [31:0] a);
    return {~a[15:0], a[15:0] ^ 16'h0F0F};
  endfunction

  function automatic logic [255:0] exp_frame(input logic [1:0] ch, input logic wd,
                                             input logic [31:0] base, input int f);
    logic [255:0] r; logic [31:0] d; int w;
    r = '0;
    w = wd ? 2 * (int'(ch) + 1) : int'(ch) + 1;
    for (int k = 0; k < w; k++) begin
      d = mword(base + 32'((f * w + k) * 4));
      if (wd) r[k*32 +: 32] = d;
      else begin
        r[(2*k)*32 +: 32]   = {16'h0, d[15:0]};
        r[(2*k+1)*32 +: 32] = {16'h0, d[31:16]};
      end
    end
    return r;
  endfunction

  always @(posedge clk) begin
    cyc  <= cyc + 1;
    gcnt <= gcnt + 1;
    if (!rst_n) begin
      aq.delete(); tq.delete(); mem_rvalid <= 0; beats <= 0;
    end else begin
      if (mem_rvalid) beats <= beats + 1;
      if (mem_req && mem_gnt)
        for (int b = 0; b < 4; b++) begin
          aq.push_back(mem_addr + 32'(4 * b));
          tq.push_back(cyc + LAT);
        end
      if (aq.size() > 0 && tq[0] <= cyc) begin
        mem_rvalid <= 1; mem_rdata <= mword(aq[0]);
        void'(aq.pop_front()); void'(tq.pop_front());
      end else mem_rvalid <= 0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] ch, input logic wd);
    @(negedge clk);
    rst_n = 0; cfg_chans = ch; cfg_wide = wd;
    slot_load = 0; fs_strobe = 0; udr_clear = 0; err_clear = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic load(input int s, input logic [31:0] a, input logic [15:0] n);
    @(negedge clk);
    slot_load[s] = 1; load_addr = a; load_len = n;
    @(negedge clk);
    slot_load = 0;
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1;
    @(negedge clk); sig = 0;
  endtask

  task automatic strobe;
    @(negedge clk); fs_strobe = 1;
    @(negedge clk); fs_strobe = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [1:0] ch; logic wd; int nf; logic [31:0] ba, bb;

    // R10 reset state
    do_reset(0, 0);
    chk(frame_valid == 0 && frame_data == '0, "R10 frame", frame_data, '0);
    chk({buf_done, irq, underrun, load_err, mem_req} == '0, "R10 flags",
        256'({buf_done, irq, underrun, load_err, mem_req}), '0);

    // R9 strobe before any load
    strobe();
    chk(frame_valid == 0 && underrun == 0, "R9 idle strobe",
        256'({frame_valid, underrun}), '0);

    // R1 R2 R3 R4 table walk over all modes
    for (int i = 0; i < 8; i++) begin
      ch = VEC[i][7:6]; wd = VEC[i][5]; nf = int'(VEC[i][4:0]);
      ba = 32'h1000 + 32'(i) * 32'h400; bb = ba + 32'h200;
      do_reset(ch, wd);
      load(0, ba, 16'd96);
      load(1, bb, 16'd96);
      repeat (60) @(negedge clk);
      for (int f = 0; f < 2 * nf; f++) begin
        strobe();
        chk(frame_valid == 1, "R2 frame pulse", 256'(frame_valid), 256'(1));
        if (f < nf)
          chk(frame_data == exp_frame(ch, wd, ba, f), "R1 slot0 frame", frame_data, exp_frame(ch, wd, ba, f));
        else if (f == nf)
          chk(frame_data == exp_frame(ch, wd, bb, 0), "R3 first frame after switch", frame_data, exp_frame(ch, wd, bb, 0));
        else
          chk(frame_data == exp_frame(ch, wd, bb, f - nf), "R1 slot1 frame", frame_data, exp_frame(ch, wd, bb, f - nf));
        if (f == nf - 1)
          chk(buf_done == 2'b01 && irq, "R4 slot0 done", 256'({buf_done, irq}), 256'(3'b011));
        repeat (15) @(negedge clk);
      end
      chk(buf_done == 2'b11 && irq, "R4 both done", 256'({buf_done, irq}), 256'(3'b111));
      if (!(wd && ch >= 2))
        chk(underrun == 0, "R5 no underrun in normal flow", 256'(underrun), '0);
    end

    // R8 fill limit and drain threshold
    do_reset(0, 0);
    load(0, 32'h8000, 16'd256);
    repeat (80) @(negedge clk);
    chk(beats == 32, "R8 fill to depth", 256'(beats), 256'(32));
    for (int k = 0; k < 3; k++) strobe();
    repeat (30) @(negedge clk);
    chk(beats == 32, "R8 no burst before four words free", 256'(beats), 256'(32));
    strobe();
    repeat (30) @(negedge clk);
    chk(beats == 36, "R8 one burst after four words free", 256'(beats), 256'(36));
    chk(frame_data == exp_frame(0, 0, 32'h8000, 3), "R1 ascending words", frame_data, exp_frame(0, 0, 32'h8000, 3));

    // R5 R6 underrun replay and stickiness
    do_reset(0, 0);
    load(0, 32'h2000, 16'd16);
    repeat (40) @(negedge clk);
    for (int k = 0; k < 4; k++) begin strobe(); repeat (10) @(negedge clk); end
    chk(underrun == 0, "R5 no underrun while data present", 256'(underrun), '0);
    strobe();
    chk(frame_valid == 1 && frame_data == exp_frame(0, 0, 32'h2000, 3), "R5 replay last frame",
        frame_data, exp_frame(0, 0, 32'h2000, 3));
    chk(underrun == 1, "R5 underrun set", 256'(underrun), 256'(1));
    repeat (5) @(negedge clk);
    strobe();
    chk(frame_data == exp_frame(0, 0, 32'h2000, 3), "R5 replay held", frame_data, exp_frame(0, 0, 32'h2000, 3));
    load(1, 32'h3000, 16'd16);
    chk(underrun == 1, "R6 load keeps underrun", 256'(underrun), 256'(1));
    repeat (30) @(negedge clk);
    strobe();
    chk(frame_data == exp_frame(0, 0, 32'h3000, 0), "R3 new buffer after underrun", frame_data, exp_frame(0, 0, 32'h3000, 0));
    chk(underrun == 1, "R6 still set after new data", 256'(underrun), 256'(1));
    load(0, 32'h4000, 16'd16);
    chk(buf_done[0] == 0, "R4 load clears done", 256'(buf_done), '0);
    pulse(udr_clear);
    chk(underrun == 0, "R6 clear", 256'(underrun), '0);

    // R7 load to an armed slot
    do_reset(0, 0);
    load(0, 32'h5000, 16'd32);
    load(0, 32'h6000, 16'd16);
    chk(load_err == 1, "R7 error set", 256'(load_err), 256'(1));
    repeat (40) @(negedge clk);
    strobe();
    chk(frame_data == exp_frame(0, 0, 32'h5000, 0), "R7 original address kept", frame_data, exp_frame(0, 0, 32'h5000, 0));
    for (int k = 1; k < 8; k++) begin strobe(); repeat (5) @(negedge clk); end
    chk(frame_data == exp_frame(0, 0, 32'h5000, 7) && buf_done[0], "R7 original length kept",
        frame_data, exp_frame(0, 0, 32'h5000, 7));
    pulse(err_clear);
    chk(load_err == 0, "R7 error clear", 256'(load_err), '0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule